// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the fixed hardware steps a 32-bit core performs between taking a synchronous exception and running the first instruction of its handler. It accepts five request lines: a reset request and four fault causes (access fault, privileged instruction, undefined instruction, floating-point fault). It samples the current status word, program counter, interrupt stack pointer and exception table base in the cycle it accepts a request. It then drives a single 32-bit memory port through the entry sequence.

For a fault, the status word is pushed onto a downward-growing interrupt stack. Three bits of the status word are then cleared: interrupt enable at bit 16, stack select at bit 17 and processor mode at bit 20. The program counter is pushed next, the handler address is read from the table base plus a per-cause offset, and that word becomes the new program counter. A reset request skips both pushes. It loads the status word and stack pointer with their initial values and reads the handler address from a fixed location at the top of the address space.

The memory port uses a valid/ready handshake, so every access may take any number of wait states. A busy flag covers the whole sequence, and a one-cycle done pulse marks the branch.

Top module: `exc_entry_seq`

## Requirements
- R1: For a fault, the first memory access is a write (mem_write=1) of the sampled status word to address isp_in-4.
- R2: When the sequence finishes, psw_out equals the sampled status word with bits 16, 17 and 20 forced to 0 and every other bit unchanged.
- R3: The second access for a fault is a write of the sampled program counter to isp_in-8, and isp_out ends at isp_in-8.
- R4: The third and last access for a fault is a read (mem_write=0) from base_in plus the cause offset: 0x54 for access fault, 0x50 for privileged instruction, 0x5C for undefined instruction, 0x64 for floating-point fault.
- R5: The 32-bit word returned by the last read is presented on pc_out in the cycle done is high.
- R6: A reset request makes exactly one access, a read from 0xFFFFFFFC, and finishes with psw_out=0 and isp_out=0.
- R7: When several request lines are high in the accepting cycle, the winner is the first of: reset, access fault, privileged instruction, undefined instruction, floating-point fault.
- R8: While mem_valid is high and mem_ready is low, mem_valid, mem_write, mem_addr and mem_wdata hold their values into the next cycle.
- R9: busy is high from the cycle after acceptance until the cycle done rises. Request lines and data inputs seen while busy have no effect, and no second sequence starts after done.
- R10: done is high for exactly one cycle per sequence.
- R11: After rst, busy, done, mem_valid, psw_out, isp_out and pc_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Reset exception request |
| req_access | input | 1 | Access fault request |
| req_priv | input | 1 | Privileged instruction request |
| req_undef | input | 1 | Undefined instruction request |
| req_fpu | input | 1 | Floating-point fault request |
| psw_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| isp_in | input | 32 | Current interrupt stack pointer |
| base_in | input | 32 | Exception table base |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts/completes the access |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the branch |
| psw_out | output | 32 | Updated status word |
| isp_out | output | 32 | Updated interrupt stack pointer |
| pc_out | output | 32 | New program counter |

## Verification
The assertions assume that the memory side raises mem_ready only while mem_valid is high, and that rdata is meaningful in the cycle ready completes a read. They also assume isp_in and base_in are word aligned, so the stack and vector addresses follow simple word arithmetic. The bench's memory model decides ready afresh each cycle, and only when an access is pending. It inserts zero to several random wait states, and every stack and table value the stimulus draws is masked to a multiple of four.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_RESET,
    CAUSE_ACCESS,
    CAUSE_PRIV,
    CAUSE_UNDEF,
    CAUSE_FPU
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_FETCH
  } state_e;

  localparam int NUM_LINES = 5;

  localparam logic [7:0] OFF_PRIV   = 8'h50;
  localparam logic [7:0] OFF_ACCESS = 8'h54;
  localparam logic [7:0] OFF_UNDEF  = 8'h5C;
  localparam logic [7:0] OFF_FPU    = 8'h64;

  // Request line index to cause; a lower index has higher priority.
  function automatic cause_e line_cause(input int idx);
    case (idx)
      0:       return CAUSE_RESET;
      1:       return CAUSE_ACCESS;
      2:       return CAUSE_PRIV;
      3:       return CAUSE_UNDEF;
      4:       return CAUSE_FPU;
      default: return CAUSE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
(
  input  logic   reset_req,
  input  logic   req_access,
  input  logic   req_priv,
  input  logic   req_undef,
  input  logic   req_fpu,
  output cause_e cause,
  output logic   any_req
);

  logic [NUM_LINES-1:0] lines;
  assign lines = {req_fpu, req_undef, req_priv, req_access, reset_req};

  // Scan from lowest priority up, so the last hit is the winner (R7).
  always_comb begin
    cause = CAUSE_NONE;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (lines[i]) cause = line_cause(i);
    end
  end

  assign any_req = |lines;

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hFFFF_FFFC
) (
  input  cause_e          cause,
  input  logic [XLEN-1:0] base,
  output logic [XLEN-1:0] vec_addr
);

  always_comb begin
    case (cause)
      CAUSE_RESET:  vec_addr = RESET_VEC;
      CAUSE_ACCESS: vec_addr = base + XLEN'(OFF_ACCESS);
      CAUSE_PRIV:   vec_addr = base + XLEN'(OFF_PRIV);
      CAUSE_UNDEF:  vec_addr = base + XLEN'(OFF_UNDEF);
      CAUSE_FPU:    vec_addr = base + XLEN'(OFF_FPU);
      default:      vec_addr = RESET_VEC;
    endcase
  end

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              IE_BIT    = 16,
  parameter int              SS_BIT    = 17,
  parameter int              PM_BIT    = 20,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hFFFF_FFFC,
  parameter logic [XLEN-1:0] RESET_ISP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            any_req,
  input  cause_e          cause_in,
  input  logic [XLEN-1:0] psw_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] isp_in,
  input  logic [XLEN-1:0] base_in,
  input  logic [XLEN-1:0] vec_addr,
  output cause_e          cause_q,
  output logic [XLEN-1:0] base_q,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] psw_out,
  output logic [XLEN-1:0] isp_out,
  output logic [XLEN-1:0] pc_out
);

  localparam int              WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP2      = XLEN'(2 * WORD_BYTES);
  localparam logic [XLEN-1:0] CLR_MASK   = (XLEN'(1) << IE_BIT) |
                                           (XLEN'(1) << SS_BIT) |
                                           (XLEN'(1) << PM_BIT);

  state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cause_q   <= CAUSE_NONE;
      base_q    <= '0;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      psw_out   <= '0;
      isp_out   <= '0;
      pc_out    <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (any_req) begin
            cause_q <= cause_in;
            base_q  <= base_in;
            busy    <= 1'b1;
            if (cause_in == CAUSE_RESET) begin
              psw_out   <= '0;
              isp_out   <= RESET_ISP;
              mem_valid <= 1'b1;
              mem_write <= 1'b0;
              mem_addr  <= RESET_VEC;
              mem_wdata <= '0;
              state_q   <= ST_FETCH;
            end else begin
              psw_out   <= psw_in;
              pc_out    <= pc_in;
              isp_out   <= isp_in;
              mem_valid <= 1'b1;
              mem_write <= 1'b1;
              mem_addr  <= isp_in - STEP;
              mem_wdata <= psw_in;
              state_q   <= ST_PUSH_SR;
            end
          end
        end
        ST_PUSH_SR: begin
          if (mem_ready) begin
            isp_out   <= isp_out - STEP;
            psw_out   <= psw_out & ~CLR_MASK;
            mem_addr  <= isp_out - STEP2;
            mem_wdata <= pc_out;
            state_q   <= ST_PUSH_PC;
          end
        end
        ST_PUSH_PC: begin
          if (mem_ready) begin
            isp_out   <= isp_out - STEP;
            mem_write <= 1'b0;
            mem_addr  <= vec_addr;
            mem_wdata <= '0;
            state_q   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            pc_out    <= mem_rdata;
            mem_valid <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              IE_BIT    = 16,
  parameter int              SS_BIT    = 17,
  parameter int              PM_BIT    = 20,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hFFFF_FFFC,
  parameter logic [XLEN-1:0] RESET_ISP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reset_req,
  input  logic            req_access,
  input  logic            req_priv,
  input  logic            req_undef,
  input  logic            req_fpu,
  input  logic [XLEN-1:0] psw_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] isp_in,
  input  logic [XLEN-1:0] base_in,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] psw_out,
  output logic [XLEN-1:0] isp_out,
  output logic [XLEN-1:0] pc_out
);

  cause_e          cause_w;
  cause_e          cause_q;
  logic            any_w;
  logic [XLEN-1:0] base_q;
  logic [XLEN-1:0] vec_w;

  exc_cause_arb u_arb (
    .reset_req (reset_req),
    .req_access(req_access),
    .req_priv  (req_priv),
    .req_undef (req_undef),
    .req_fpu   (req_fpu),
    .cause     (cause_w),
    .any_req   (any_w)
  );

  exc_vec_gen #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_vec (
    .cause   (cause_q),
    .base    (base_q),
    .vec_addr(vec_w)
  );

  exc_entry_fsm #(
    .XLEN(XLEN), .IE_BIT(IE_BIT), .SS_BIT(SS_BIT), .PM_BIT(PM_BIT),
    .RESET_VEC(RESET_VEC), .RESET_ISP(RESET_ISP)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .any_req  (any_w),
    .cause_in (cause_w),
    .psw_in   (psw_in),
    .pc_in    (pc_in),
    .isp_in   (isp_in),
    .base_in  (base_in),
    .vec_addr (vec_w),
    .cause_q  (cause_q),
    .base_q   (base_q),
    .mem_valid(mem_valid),
    .mem_write(mem_write),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ready(mem_ready),
    .mem_rdata(mem_rdata),
    .busy     (busy),
    .done     (done),
    .psw_out  (psw_out),
    .isp_out  (isp_out),
    .pc_out   (pc_out)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int IE_BIT = 16,
  parameter int SS_BIT = 17,
  parameter int PM_BIT = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_valid,
  input logic            mem_write,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            mem_ready,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] psw_out,
  input logic [XLEN-1:0] isp_out
);

  localparam logic [XLEN-1:0] MASK = (XLEN'(1) << IE_BIT) |
                                     (XLEN'(1) << SS_BIT) |
                                     (XLEN'(1) << PM_BIT);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  a_r8_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  a_r3_push_below_sp: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write) |-> (mem_addr == isp_out - STEP));

  a_r2_bits_cleared: assert property (@(posedge clk) disable iff (rst)
    done |-> ((psw_out & MASK) == '0));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_not_busy_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN(XLEN), .IE_BIT(IE_BIT), .SS_BIT(SS_BIT), .PM_BIT(PM_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_valid(mem_valid),
  .mem_write(mem_write),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ready(mem_ready),
  .busy     (busy),
  .done     (done),
  .psw_out  (psw_out),
  .isp_out  (isp_out)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_req = 0, req_access = 0, req_priv = 0, req_undef = 0, req_fpu = 0;
  logic [31:0] psw_in = '0, pc_in = '0, isp_in = '0, base_in = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, done;
  logic [31:0] psw_out, isp_out, pc_out;

  always #2 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst),
    .reset_req(reset_req), .req_access(req_access), .req_priv(req_priv),
    .req_undef(req_undef), .req_fpu(req_fpu),
    .psw_in(psw_in), .pc_in(pc_in), .isp_in(isp_in), .base_in(base_in),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .psw_out(psw_out), .isp_out(isp_out), .pc_out(pc_out)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit nowait = 1'b0;
  int tx_n   = 0;
  logic [31:0] log_addr [4];
  logic [31:0] log_data [4];
  logic        log_wr   [4];
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] prev_wdata = '0;

  localparam logic [31:0] CLR = 32'h0013_0000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  // Memory model: ready decided each cycle, only while an access is pending.
  always @(negedge clk) begin
    cycles++;
    if (prev_pend) begin
      chk(mem_valid && mem_addr == prev_addr && mem_wdata == prev_wdata,
          "R8 hold", mem_addr, prev_addr);
    end
    if (mem_valid && (nowait || $urandom_range(0, 2) == 0)) begin
      mem_ready = 1'b1;
      mem_rdata = mem_word(mem_addr);
      if (tx_n < 4) begin
        log_addr[tx_n] = mem_addr;
        log_data[tx_n] = mem_wdata;
        log_wr[tx_n]   = mem_write;
      end
      tx_n++;
      prev_pend = 1'b0;
    end else begin
      mem_ready  = 1'b0;
      prev_pend  = mem_valid;
      prev_addr  = mem_addr;
      prev_wdata = mem_wdata;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // rq = {reset, access, priv, undef, fpu}
  task automatic run_exc(input logic [4:0] rq, input logic [31:0] psw,
                         input logic [31:0] pc, input logic [31:0] isp,
                         input logic [31:0] base, input bit hammer);
    logic [31:0] off;
    int n;
    @(negedge clk);
    {reset_req, req_access, req_priv, req_undef, req_fpu} = rq;
    psw_in = psw; pc_in = pc; isp_in = isp; base_in = base;
    tx_n = 0;
    @(negedge clk);
    {reset_req, req_access, req_priv, req_undef, req_fpu} = '0;
    chk(busy == 1'b1, "R9 busy", {31'd0, busy}, 32'd1);
    if (hammer) begin
      {reset_req, req_access, req_priv, req_undef, req_fpu} = 5'b11111;
      psw_in = ~psw; pc_in = ~pc; isp_in = isp ^ 32'h100; base_in = base ^ 32'h1000;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    {reset_req, req_access, req_priv, req_undef, req_fpu} = '0;
    chk(done == 1'b1, "R9 finish", {31'd0, done}, 32'd1);
    if (rq[4]) begin
      chk(tx_n == 1, "R6 count", tx_n, 1);
      chk(log_wr[0] == 1'b0 && log_addr[0] == 32'hFFFF_FFFC, "R6 addr",
          log_addr[0], 32'hFFFF_FFFC);
      chk(psw_out == '0 && isp_out == '0, "R6 regs", psw_out | isp_out, 32'd0);
      chk(pc_out == mem_word(32'hFFFF_FFFC), "R5 pc", pc_out, mem_word(32'hFFFF_FFFC));
    end else begin
      // R7 priority among faults
      if (rq[3])      off = 32'h54;
      else if (rq[2]) off = 32'h50;
      else if (rq[1]) off = 32'h5C;
      else            off = 32'h64;
      chk(tx_n == 3, "R1 count", tx_n, 3);
      chk(log_wr[0] && log_addr[0] == isp - 4, "R1 addr", log_addr[0], isp - 4);
      chk(log_data[0] == psw, "R1 data", log_data[0], psw);
      chk(log_wr[1] && log_addr[1] == isp - 8, "R3 addr", log_addr[1], isp - 8);
      chk(log_data[1] == pc, "R3 data", log_data[1], pc);
      chk(isp_out == isp - 8, "R3 isp", isp_out, isp - 8);
      chk(!log_wr[2] && log_addr[2] == base + off, "R4 R7 vector", log_addr[2], base + off);
      chk(psw_out == (psw & ~CLR), "R2 psw", psw_out, psw & ~CLR);
      chk(pc_out == mem_word(base + off), "R5 pc", pc_out, mem_word(base + off));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 pulse", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(busy == 1'b0 && mem_valid == 1'b0, "R9 ignored", {30'd0, busy, mem_valid}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_valid == 0, "R11 ctrl",
        {29'd0, busy, done, mem_valid}, 32'd0);
    chk(psw_out == 0 && isp_out == 0 && pc_out == 0, "R11 regs",
        psw_out | isp_out | pc_out, 32'd0);

    nowait = 1'b1;
    run_exc(5'b00010, 32'hFFFF_FFFF, 32'h0000_1234, 32'h0000_8000, 32'h0001_0000, 0); // R2 all ones
    run_exc(5'b00100, 32'h0013_0005, 32'h0000_2000, 32'h0000_4000, 32'h0002_0000, 0);
    nowait = 1'b0;
    run_exc(5'b01000, 32'h1234_5678, 32'h0000_3000, 32'h0000_6000, 32'h0003_0000, 0);
    run_exc(5'b00001, 32'h00EC_FFFF, 32'h0000_4444, 32'h0000_0008, 32'h0004_0000, 0);
    run_exc(5'b10000, 32'hFFFF_FFFF, 32'h0000_5555, 32'h0000_7000, 32'h0005_0000, 0); // R6
    run_exc(5'b11111, 32'h0000_0001, 32'h0000_6666, 32'h0000_9000, 32'h0006_0000, 0); // R7
    run_exc(5'b01010, 32'hA5A5_A5A5, 32'h0000_7777, 32'h0000_A000, 32'h0007_0000, 0); // R7
    run_exc(5'b00101, 32'h5A5A_5A5A, 32'h0000_8888, 32'h0000_B000, 32'h0008_0000, 0); // R7
    run_exc(5'b00011, 32'h0F0F_0F0F, 32'h0000_9999, 32'h0000_C000, 32'h0009_0000, 1); // R9
    run_exc(5'b10000, 32'h0F0F_0F0F, 32'h0000_AAAA, 32'h0000_D000, 32'h000A_0000, 1); // R9

    for (int k = 0; k < 40; k++) begin
      logic [4:0] rq;
      rq = 5'($urandom_range(1, 31));
      if (rq[4] && $urandom_range(0, 3) != 0) rq[4] = 1'b0;
      if (rq == '0) rq = 5'b00001;
      run_exc(rq, $urandom, $urandom & ~32'h3, ($urandom & ~32'h3) | 32'h10,
              $urandom & ~32'h3, bit'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule